// File: doc/BRIEF.md
# Banked Video Window Address Translator

This block turns a processor access that lands in the display memory window into a linear address inside video memory. The window-relative offset is formed from the low address bits, one of two bank offset registers is picked (optionally by the upper half of the window), scaled by a 4 KB or 16 KB granule and added in. A plane number then comes from the address itself (chain-4 or odd/even addressing) or from a read plane selector. Reads normally get a plane-qualified address into four 1 MB planes; writes and the compare read mode get the plane-0 offset only, since plane enabling happens further down the data path.

Translation is combinational and is captured in one register stage. A valid strobe on the input produces a valid result on the following clock; without a strobe the last result is held.

Top module: `vwin_xlate`

## Requirements
- R1: The window offset is (cpu_addr - win_base) modulo 2^16, with both inputs 16 bits wide.
- R2: When dual_win is 1 and window offset bit 15 is 1, bank_ofs1 is used; in every other case bank_ofs0 is used.
- R3: The chosen bank value is shifted left by 14 when coarse_gran is 1 and by 12 otherwise, and byte_ofs = (aligned window offset + scaled bank) modulo 2^20.
- R4: When chain4 is 1 (it has priority over odd/even), the plane is window offset bits [1:0] and those two bits are cleared in the aligned offset.
- R5: When chain4 is 0 and odd_even is 1, the plane is {0, window offset bit 0} and bit 0 is cleared in the aligned offset.
- R6: When neither chain4 nor odd_even is set, the plane is rd_plane[1:0] and the offset is not altered.
- R7: For a read (is_write 0) with rd_cmp_mode 0, lin_addr = plane * 2^20 + byte_ofs (plane in bits [21:20]); with rd_cmp_mode 1, lin_addr = byte_ofs with bits [21:20] zero.
- R8: For a write (is_write 1), lin_addr = byte_ofs with bits [21:20] zero, whatever the plane mode.
- R9: out_vld is 1 exactly one cycle after req_vld was 1; while req_vld is 0 the outputs hold; a synchronous reset (rst_n 0) clears out_vld, byte_ofs and lin_addr to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Access strobe; inputs are valid |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| cpu_addr | input | 16 | Low bits of the processor address |
| win_base | input | 16 | Low bits of the window base address |
| dual_win | input | 1 | Enable two windows split at offset bit 15 |
| coarse_gran | input | 1 | 1: 16 KB granule, 0: 4 KB granule |
| bank_ofs0 | input | 8 | Bank offset register for the lower/only window |
| bank_ofs1 | input | 8 | Bank offset register for the upper window |
| chain4 | input | 1 | Chain-4 addressing enable |
| odd_even | input | 1 | Odd/even addressing enable |
| rd_plane | input | 2 | Read plane selector |
| rd_cmp_mode | input | 1 | Compare read mode; returns the plane-0 offset |
| out_vld | output | 1 | Registered result is valid |
| byte_ofs | output | 20 | Translated offset within a plane |
| lin_addr | output | 22 | Plane-qualified linear address |

## Verification
Directed accesses place the address below the base (wrap of the subtraction), on both sides of offset bit 15 with the dual window on and off, and with zero, small and maximum bank values at both granules, which separates a wrong register choice, a wrong shift and a missing 20-bit wrap. Each plane mode is tried with addresses whose low bits are all non-zero, so a missing clear or a wrong plane source shows up in both outputs, and the same accesses are repeated as writes and compare-mode reads to show the plane bits drop. Idle cycles between strobes show that the result holds, and a run of random accesses compares every output on every clock with a behavioural model.

// File: rtl/vwin_pkg.sv
// Shared constants and types for the video window address translator.
// Assumes four planes of 1 MB each and a 16-bit window.
package vwin_pkg;
    localparam int unsigned WIN_W      = 16;
    localparam int unsigned PLANE_AW   = 20;
    localparam int unsigned PLANE_CNT  = 4;
    localparam int unsigned PLANE_SW   = $clog2(PLANE_CNT);
    localparam int unsigned LIN_W      = PLANE_AW + PLANE_SW;
    localparam int unsigned BANK_W     = 8;
    localparam int unsigned FINE_SH    = 12;
    localparam int unsigned COARSE_SH  = 14;

    // How the plane number is derived for an access
    typedef enum logic [1:0] {
        PM_SELECT = 2'd0,
        PM_PAIRED = 2'd1,
        PM_QUAD   = 2'd2
    } plane_mode_e;
endpackage

// File: rtl/vwin_bank_sel.sv
// Picks one of two bank offset registers and scales it by the granule.
// Assumes the register value fits after shifting; upper bits are dropped
// so the result wraps inside one plane.
module vwin_bank_sel #(
    parameter int unsigned BANK_W    = 8,
    parameter int unsigned PLANE_AW  = 20,
    parameter int unsigned FINE_SH   = 12,
    parameter int unsigned COARSE_SH = 14
) (
    input  logic                upper_half,
    input  logic                dual_en,
    input  logic                coarse,
    input  logic [BANK_W-1:0]   ofs0,
    input  logic [BANK_W-1:0]   ofs1,
    output logic [PLANE_AW-1:0] bank_base
);
    logic [BANK_W-1:0]   chosen;
    logic [PLANE_AW-1:0] widened;

    // Select the register for the half of the window being accessed
    always_comb begin
        chosen = (dual_en && upper_half) ? ofs1 : ofs0;
    end

    // Scale by the granule; a zero register contributes nothing
    always_comb begin
        widened = PLANE_AW'(chosen);
        if (chosen == '0)
            bank_base = '0;
        else if (coarse)
            bank_base = widened << COARSE_SH;
        else
            bank_base = widened << FINE_SH;
    end
endmodule

// File: rtl/vwin_plane_map.sv
// Derives the plane number and the plane-aligned offset from the
// window offset. Chain-4 takes priority over odd/even addressing.
module vwin_plane_map
    import vwin_pkg::*;
#(
    parameter int unsigned OFS_W = 16,
    parameter int unsigned SEL_W = 2
) (
    input  logic             quad_en,
    input  logic             paired_en,
    input  logic [SEL_W-1:0] plane_sel,
    input  logic [OFS_W-1:0] win_ofs,
    output logic [SEL_W-1:0] plane,
    output logic [OFS_W-1:0] aligned_ofs
);
    plane_mode_e mode;

    // Decode the addressing mode with chain-4 first
    always_comb begin
        if (quad_en)
            mode = PM_QUAD;
        else if (paired_en)
            mode = PM_PAIRED;
        else
            mode = PM_SELECT;
    end

    // Form the plane and clear the address bits that selected it
    always_comb begin
        plane       = plane_sel;
        aligned_ofs = win_ofs;
        case (mode)
            PM_QUAD: begin
                plane       = SEL_W'(win_ofs[1:0]);
                aligned_ofs = {win_ofs[OFS_W-1:2], 2'b00};
            end
            PM_PAIRED: begin
                plane       = SEL_W'(win_ofs[0]);
                aligned_ofs = {win_ofs[OFS_W-1:1], 1'b0};
            end
            default: begin
                plane       = plane_sel;
                aligned_ofs = win_ofs;
            end
        endcase
    end
endmodule

// File: rtl/vwin_xlate.sv
// Top of the banked video window address translator. Combinational
// translation of one access, captured one cycle after a valid strobe.
// Assumes inputs are stable around the clock edge where req_vld is 1.
module vwin_xlate
    import vwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_vld,
    input  logic                is_write,
    input  logic [WIN_W-1:0]    cpu_addr,
    input  logic [WIN_W-1:0]    win_base,
    input  logic                dual_win,
    input  logic                coarse_gran,
    input  logic [BANK_W-1:0]   bank_ofs0,
    input  logic [BANK_W-1:0]   bank_ofs1,
    input  logic                chain4,
    input  logic                odd_even,
    input  logic [1:0]          rd_plane,
    input  logic                rd_cmp_mode,
    output logic                out_vld,
    output logic [PLANE_AW-1:0] byte_ofs,
    output logic [LIN_W-1:0]    lin_addr
);
    logic [WIN_W-1:0]    win_ofs;
    logic [WIN_W-1:0]    aligned_ofs;
    logic [PLANE_SW-1:0] plane;
    logic [PLANE_AW-1:0] bank_base;
    logic [PLANE_AW-1:0] ofs_next;
    logic [LIN_W-1:0]    lin_next;

    // Window-relative offset, wrapping in 16 bits
    always_comb begin
        win_ofs = cpu_addr - win_base;
    end

    vwin_bank_sel #(
        .BANK_W    (BANK_W),
        .PLANE_AW  (PLANE_AW),
        .FINE_SH   (FINE_SH),
        .COARSE_SH (COARSE_SH)
    ) u_bank (
        .upper_half (win_ofs[WIN_W-1]),
        .dual_en    (dual_win),
        .coarse     (coarse_gran),
        .ofs0       (bank_ofs0),
        .ofs1       (bank_ofs1),
        .bank_base  (bank_base)
    );

    vwin_plane_map #(
        .OFS_W (WIN_W),
        .SEL_W (PLANE_SW)
    ) u_plane (
        .quad_en     (chain4),
        .paired_en   (odd_even),
        .plane_sel   (rd_plane),
        .win_ofs     (win_ofs),
        .plane       (plane),
        .aligned_ofs (aligned_ofs)
    );

    // Add the bank base and qualify with the plane for normal reads
    always_comb begin
        ofs_next = PLANE_AW'(aligned_ofs) + bank_base;
        if (is_write || rd_cmp_mode)
            lin_next = {{PLANE_SW{1'b0}}, ofs_next};
        else
            lin_next = {plane, ofs_next};
    end

    // Output register: capture on a strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            byte_ofs <= '0;
            lin_addr <= '0;
        end else begin
            out_vld <= req_vld;
            if (req_vld) begin
                byte_ofs <= ofs_next;
                lin_addr <= lin_next;
            end
        end
    end

    // R9: a strobe yields a valid result on the next cycle
    a_r9_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> out_vld);

    // R9: with no strobe the result holds and is not marked valid
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!out_vld && $stable(byte_ofs) && $stable(lin_addr)));

    // R8: writes never carry a plane number
    a_r8_write_plane0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && is_write) |=> (lin_addr[LIN_W-1:PLANE_AW] == '0));

    // R7: compare-mode reads never carry a plane number
    a_r7_cmp_plane0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !is_write && rd_cmp_mode) |=> (lin_addr[LIN_W-1:PLANE_AW] == '0));

    // R7: the in-plane part of the linear address is the byte offset
    a_r7_low_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (lin_addr[PLANE_AW-1:0] == byte_ofs));
endmodule

// File: tb/vwin_xlate_bench.sv
`timescale 1ns/1ps
module vwin_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        is_write = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [15:0] win_base = '0;
    logic        dual_win = 1'b0;
    logic        coarse_gran = 1'b0;
    logic [7:0]  bank_ofs0 = '0;
    logic [7:0]  bank_ofs1 = '0;
    logic        chain4 = 1'b0;
    logic        odd_even = 1'b0;
    logic [1:0]  rd_plane = '0;
    logic        rd_cmp_mode = 1'b0;
    logic        out_vld;
    logic [19:0] byte_ofs;
    logic [21:0] lin_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // expected state of the registered outputs
    int exp_vld = 0;
    int exp_ofs = 0;
    int exp_lin = 0;

    always #2 clk = ~clk;

    vwin_xlate u_vwin_xlate (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .is_write(is_write),
        .cpu_addr(cpu_addr), .win_base(win_base), .dual_win(dual_win),
        .coarse_gran(coarse_gran), .bank_ofs0(bank_ofs0), .bank_ofs1(bank_ofs1),
        .chain4(chain4), .odd_even(odd_even), .rd_plane(rd_plane),
        .rd_cmp_mode(rd_cmp_mode), .out_vld(out_vld), .byte_ofs(byte_ofs),
        .lin_addr(lin_addr)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural model of one translation, from the requirements
    task automatic model(output int ofs, output int lin);
        int w, bank, plane, scaled;
        w = (int'(cpu_addr) - int'(win_base)) & 32'hFFFF;           // R1
        bank = (dual_win && (w >= 32768)) ? int'(bank_ofs1) : int'(bank_ofs0); // R2
        if (chain4) begin plane = w % 4; w = w - (w % 4); end          // R4
        else if (odd_even) begin plane = w % 2; w = w - (w % 2); end  // R5
        else plane = int'(rd_plane);                                   // R6
        scaled = bank * (coarse_gran ? 16384 : 4096);                  // R3
        ofs = (w + scaled) % 1048576;
        if (is_write || rd_cmp_mode) lin = ofs;                        // R7 R8
        else lin = plane * 1048576 + ofs;
    endtask

    // One clock: drive at the falling edge, compare after the rising edge
    task automatic step(input bit vld, input string tag);
        int o, l;
        @(negedge clk);
        req_vld = vld;
        if (vld) begin
            model(o, l);
            exp_ofs = o;
            exp_lin = l;
        end
        exp_vld = vld;
        @(posedge clk);
        #1;
        check("R9", "out_vld", int'(out_vld), exp_vld);
        check(tag, "byte_ofs", int'(byte_ofs), exp_ofs);
        check(tag, "lin_addr", int'(lin_addr), exp_lin);
    endtask

    task automatic set_acc(input bit wr, input int a, input int b);
        is_write = wr;
        cpu_addr = 16'(a);
        win_base = 16'(b);
    endtask

    initial begin
        #(4 * 5000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9", "reset out_vld", int'(out_vld), 0);
        check("R9", "reset byte_ofs", int'(byte_ofs), 0);
        check("R9", "reset lin_addr", int'(lin_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: subtraction, including wrap below the base
        set_acc(0, 16'h1234, 16'h0000); step(1, "R1");
        set_acc(0, 16'h0010, 16'h0020); step(1, "R1");
        // R2: dual window on, upper half uses second register
        dual_win = 1; bank_ofs0 = 8'h03; bank_ofs1 = 8'h05;
        set_acc(0, 16'h8004, 16'h0000); step(1, "R2");
        set_acc(0, 16'h7FF0, 16'h0000); step(1, "R2");
        // R2: dual window off, upper half still uses first register
        dual_win = 0;
        set_acc(0, 16'h8004, 16'h0000); step(1, "R2");
        // R3: coarse granule, zero bank, maximum wrap
        coarse_gran = 1; step(1, "R3");
        bank_ofs0 = 8'h00; step(1, "R3");
        bank_ofs0 = 8'hFF; set_acc(0, 16'hFFFF, 16'h0000); step(1, "R3");
        coarse_gran = 0; step(1, "R3");
        bank_ofs0 = 8'h02;
        // R6: plane from selector
        rd_plane = 2'd3; set_acc(0, 16'h0107, 16'h0000); step(1, "R6");
        rd_plane = 2'd1; step(1, "R6");
        // R5: odd/even
        odd_even = 1; step(1, "R5");
        set_acc(0, 16'h0106, 16'h0000); step(1, "R5");
        // R4: chain-4 priority over odd/even
        chain4 = 1; set_acc(0, 16'h0107, 16'h0000); step(1, "R4");
        set_acc(0, 16'h010A, 16'h0000); step(1, "R4");
        // R7: compare read mode drops the plane
        rd_cmp_mode = 1; set_acc(0, 16'h0107, 16'h0000); step(1, "R7");
        rd_cmp_mode = 0; step(1, "R7");
        // R8: writes drop the plane in every mode
        set_acc(1, 16'h0107, 16'h0000); step(1, "R8");
        chain4 = 0; step(1, "R8");
        odd_even = 0; rd_plane = 2'd2; step(1, "R8");
        // R9: idle cycles hold the result even when inputs move
        set_acc(0, 16'hABCD, 16'h0011); bank_ofs0 = 8'h77;
        step(0, "R9"); step(0, "R9");
        step(1, "R9");

        // Random accesses against the model
        for (int i = 0; i < 200; i++) begin
            set_acc(1'($urandom), int'($urandom), int'($urandom));
            dual_win    = 1'($urandom);
            coarse_gran = 1'($urandom);
            bank_ofs0   = 8'($urandom);
            bank_ofs1   = 8'($urandom);
            chain4      = 1'($urandom);
            odd_even    = 1'($urandom);
            rd_plane    = 2'($urandom);
            rd_cmp_mode = 1'($urandom);
            step(1'($urandom % 4 != 0), "R3");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule